// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Watchdog Mode

This block is one timer channel driven through three 32-bit registers on a simple register bus. A write completes in a single clock, and reads are combinational. The block counts input clocks through a 16-bit divider and a 16-bit period counter. The total span is the divider value times the period value. At the end of the span the channel either raises a timer event or, when armed as a watchdog, emits a reset pulse.

The channel has three function states:

- `ST_IDLE`: the counters are frozen.
- `ST_RUN`: the counters are active.
- `ST_HOLD`: a single-shot span has finished and the channel is parked.

It moves between them as follows:

- *start*, `ST_IDLE`→`ST_RUN`: the channel is enabled in timer function.
- *expire-single*, `ST_RUN`→`ST_HOLD`: a span ends while neither continuous operation nor the watchdog is selected.
- *reload*, `ST_RUN`→`ST_RUN`: a span ends in continuous or watchdog operation.
- *restart*, `ST_RUN`→`ST_RUN`: the count register is written, or a keep-alive arrives while the watchdog is armed.
- *rearm*, `ST_HOLD`→`ST_RUN`: the count register is written.
- *stop*, `ST_RUN` or `ST_HOLD`→`ST_IDLE`: the enable is cleared or the function field leaves the timer code.

Software keeps an armed watchdog alive by writing a magic byte into the top byte of the mode register. While the watchdog is armed the interrupt path is held off.

Top module: `presc_wdog_timer`

## Requirements
- R1: After reset, all three registers read 0, and `evt_flag`, `irq` and `wdt_rst` are low.
- R2: Register layout and span length.
  - Register addresses are: 0 for mode, 1 for count, 2 for status.
  - The count register holds the divider D in bits 31:16 and the period P in bits 15:0.
  - A D or P of 0 stands for 65536.
  - With mode bit 12 set and mode bits 2:0 equal to 4, the first expiry is visible exactly D×P clocks after the clock edge of the enabling mode write.
- R3: With mode bit 10 clear (single-shot), the channel expires once and then raises no further event.
- R4: With mode bit 10 set (continuous), the channel expires again every D×P clocks.
- R5: Counting happens only while mode bit 12 is 1 and mode bits 2:0 are 4. Any other function code, or clearing bit 12, keeps the event from occurring.
- R6: Status register behaviour.
  - Bit 0 is the timer event flag and bit 1 is the watchdog expiry flag.
  - Writing 1 to a flag clears it, except that a flag set in the same cycle stays set.
  - Bits 3:2, and the bits above them, always read 0.
  - `evt_flag` mirrors bit 0.
- R7: `irq` is high exactly when status bit 0, mode bit 8 (interrupt enable) and the inverse of mode bit 15 (watchdog enable) are all 1.
- R8: Mode read-back.
  - A mode write stores bits 2:0, 8, 10, 12 and 15, and all other bits read 0.
  - If the written value has bit 15 set, bit 8 is stored as 0.
- R9: Watchdog expiry.
  - With bit 15 set, expiry drives `wdt_rst` high for exactly one clock and sets status bit 1, but not bit 0.
  - The channel then reloads and expires again D×P clocks later.
- R10: Keep-alive.
  - A mode write whose bits 31:24 are 0xA5 leaves the mode register unchanged.
  - With bit 15 set, such a write restarts the span from its edge.
  - With bit 15 clear, it has no effect on timing.
- R11: Writing the count register while running restarts both counters from the new values, so the next expiry comes D'×P' clocks after that write.
- R12: In the parked single-shot state, writing the count register rearms the channel for a fresh span of D×P clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | 2 | Register address: 0 mode, 1 count, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_flag | output | 1 | Timer event flag (status bit 0) |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The embedded properties check several rules on every cycle:

- the interrupt stays masked while the watchdog is armed;
- a reset pulse only follows a running, armed watchdog;
- the parked state is reached only from single-shot operation;
- frozen counters hold still while idle;
- a flag set always wins over a clear written in the same cycle.

Only the bench's scenarios can show the following:

- the exact D×P span length across a sweep of small divider and period values, and the 65536 wrap of a zero field;
- continuous re-expiry spacing;
- restart timing after count writes and keep-alives, and the fact that a keep-alive has no effect without the watchdog.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int          DATA_W    = 32;
    localparam logic [1:0]  ADDR_MODE = 2'd0;
    localparam logic [1:0]  ADDR_CNT  = 2'd1;
    localparam logic [1:0]  ADDR_STAT = 2'd2;

    // mode register field positions (software visible)
    localparam int          FN_LSB    = 0;
    localparam int          FN_W      = 3;
    localparam int          IRQ_BIT   = 8;
    localparam int          CONT_BIT  = 10;
    localparam int          EN_BIT    = 12;
    localparam int          WDT_BIT   = 15;
    localparam int          KICK_LSB  = 24;
    localparam logic [7:0]  KICK_BYTE = 8'hA5;
    localparam logic [2:0]  FN_TIMER  = 3'd4;

    // count register: divider in the upper half, period in the lower half
    localparam int          PRE_LSB   = 16;
    localparam int          STAT_W    = 2;

    typedef struct packed {
        logic       wdt;
        logic       en;
        logic       cont;
        logic       irq;
        logic [2:0] fn;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic         zero,
    output logic [W-1:0] val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= load_val;
        end else if (step) begin
            if (val == '0) val <= load_val;
            else           val <= val - 1'b1;
        end
    end

    assign zero = (val == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fire_tmr,
    input  logic              fire_wdt,
    output mode_t             mode_q,
    output logic              run_req,
    output logic [DIV_W-1:0]  presc_nxt,
    output logic [PER_W-1:0]  period_nxt,
    output logic              cnt_wr,
    output logic              kick,
    output logic [STAT_W-1:0] stat_q
);
    mode_t              mode_nxt;
    logic [DIV_W-1:0]   presc_q;
    logic [PER_W-1:0]   period_q;
    logic               mode_hit, cnt_hit, stat_hit, kick_byte;
    logic [STAT_W-1:0]  stat_set, stat_clr;

    assign mode_hit  = bus_wr && (bus_addr == ADDR_MODE);
    assign cnt_hit   = bus_wr && (bus_addr == ADDR_CNT);
    assign stat_hit  = bus_wr && (bus_addr == ADDR_STAT);
    assign kick_byte = (bus_wdata[KICK_LSB +: 8] == KICK_BYTE);
    assign kick      = mode_hit && kick_byte;
    assign cnt_wr    = cnt_hit;

    always_comb begin
        mode_nxt = mode_q;
        if (mode_hit && !kick_byte) begin
            mode_nxt.fn   = bus_wdata[FN_LSB +: FN_W];
            mode_nxt.irq  = bus_wdata[IRQ_BIT] & ~bus_wdata[WDT_BIT];
            mode_nxt.cont = bus_wdata[CONT_BIT];
            mode_nxt.en   = bus_wdata[EN_BIT];
            mode_nxt.wdt  = bus_wdata[WDT_BIT];
        end
    end

    assign run_req    = mode_nxt.en && (mode_nxt.fn == FN_TIMER);
    assign presc_nxt  = cnt_hit ? bus_wdata[PRE_LSB +: DIV_W] : presc_q;
    assign period_nxt = cnt_hit ? bus_wdata[0 +: PER_W]       : period_q;
    assign stat_set   = {fire_wdt, fire_tmr};
    assign stat_clr   = stat_hit ? bus_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            presc_q  <= '0;
            period_q <= '0;
            stat_q   <= '0;
        end else begin
            mode_q   <= mode_nxt;
            presc_q  <= presc_nxt;
            period_q <= period_nxt;
            stat_q   <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_MODE: begin
                bus_rdata[FN_LSB +: FN_W] = mode_q.fn;
                bus_rdata[IRQ_BIT]        = mode_q.irq;
                bus_rdata[CONT_BIT]       = mode_q.cont;
                bus_rdata[EN_BIT]         = mode_q.en;
                bus_rdata[WDT_BIT]        = mode_q.wdt;
            end
            ADDR_CNT: begin
                bus_rdata[PRE_LSB +: DIV_W] = presc_q;
                bus_rdata[0 +: PER_W]       = period_q;
            end
            ADDR_STAT: bus_rdata[STAT_W-1:0] = stat_q;
            default:   bus_rdata = '0;
        endcase
    end

    AST_WDT_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.wdt |-> !mode_q.irq); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fire_tmr |=> stat_q[0]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && bus_wdata[0] && !fire_tmr) |=> !stat_q[0]); // R6
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             cont_q,
    input  logic             wdt_q,
    input  logic [DIV_W-1:0] presc_nxt,
    input  logic [PER_W-1:0] period_nxt,
    input  logic             cnt_wr,
    input  logic             kick,
    output logic             fire_tmr,
    output logic             fire_wdt,
    output logic             wdt_rst
);
    tmr_state_e       st_q, st_d;
    logic             restart, ld, step, expire;
    logic             pre_zero, per_zero;
    logic [DIV_W-1:0] pre_val, pre_ld;
    logic [PER_W-1:0] per_val, per_ld;

    assign restart = cnt_wr || (kick && wdt_q);
    // one-based fields: value-1 with wrap makes 0 count 2**W clocks
    assign pre_ld  = presc_nxt - 1'b1;
    assign per_ld  = period_nxt - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run_req) st_d = ST_RUN;
            ST_RUN: begin
                if (!run_req)                      st_d = ST_IDLE;
                else if (restart)                  st_d = ST_RUN;
                else if (expire && !cont_q && !wdt_q) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!run_req)     st_d = ST_IDLE;
                else if (restart) st_d = ST_RUN;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld       = run_req && ((st_q == ST_IDLE) || restart);
        step     = (st_q == ST_RUN) && !ld;
        expire   = step && pre_zero && per_zero;
        fire_tmr = expire && !wdt_q;
        fire_wdt = expire && wdt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_rst <= 1'b0;
        else        wdt_rst <= fire_wdt;
    end

    tmr_downcnt #(.W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(ld), .step(step),
        .load_val(pre_ld), .zero(pre_zero), .val(pre_val)
    );

    tmr_downcnt #(.W(PER_W)) u_per (
        .clk(clk), .rst_n(rst_n), .load(ld), .step(step && pre_zero),
        .load_val(per_ld), .zero(per_zero), .val(per_val)
    );

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && st_d == ST_IDLE) |=> ($stable(per_val) && $stable(pre_val))); // R5
    AST_HOLD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && $past(st_q) == ST_RUN) |-> $past(!cont_q && !wdt_q)); // R3
    AST_RST_FROM_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> ($past(wdt_q) && $past(st_q) == ST_RUN)); // R9
endmodule

// File: rtl/presc_wdog_timer.sv
module presc_wdog_timer
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              evt_flag,
    output logic              irq,
    output logic              wdt_rst
);
    mode_t             mode_q;
    logic              run_req, cnt_wr, kick, fire_tmr, fire_wdt;
    logic [DIV_W-1:0]  presc_nxt;
    logic [PER_W-1:0]  period_nxt;
    logic [STAT_W-1:0] stat_q;

    tmr_regs #(.DIV_W(DIV_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fire_tmr(fire_tmr), .fire_wdt(fire_wdt), .mode_q(mode_q),
        .run_req(run_req), .presc_nxt(presc_nxt), .period_nxt(period_nxt),
        .cnt_wr(cnt_wr), .kick(kick), .stat_q(stat_q)
    );

    tmr_ctrl #(.DIV_W(DIV_W), .PER_W(PER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_req(run_req),
        .cont_q(mode_q.cont), .wdt_q(mode_q.wdt),
        .presc_nxt(presc_nxt), .period_nxt(period_nxt),
        .cnt_wr(cnt_wr), .kick(kick),
        .fire_tmr(fire_tmr), .fire_wdt(fire_wdt), .wdt_rst(wdt_rst)
    );

    assign evt_flag = stat_q[0];
    assign irq      = stat_q[0] && mode_q.irq && !mode_q.wdt;

    AST_WDT_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> !irq); // R7
endmodule

// File: tb/presc_wdog_timer_tb_top.sv
module presc_wdog_timer_tb_top;
    localparam logic [31:0] M_ON   = 32'h0000_1004;
    localparam logic [31:0] M_CONT = 32'h0000_0400;
    localparam logic [31:0] M_IRQ  = 32'h0000_0100;
    localparam logic [31:0] M_WDT  = 32'h0000_8000;
    localparam logic [31:0] M_KICK = 32'hA500_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_flag, irq, wdt_rst;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    presc_wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_flag(evt_flag), .irq(irq), .wdt_rst(wdt_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic start(input logic [15:0] d, input logic [15:0] p, input logic [31:0] m);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hF);
        wr(2'd1, {d, p});
        wr(2'd0, m);
    endtask

    // k = negedges after the last write edge until the selected output is seen high
    task automatic wait_evt(input int sel, input int lim, output int k);
        k = 0;
        while (k <= lim) begin
            @(negedge clk);
            if ((sel == 0 && evt_flag) || (sel == 1 && wdt_rst)) break;
            k++;
        end
    endtask

    function automatic int span(input int d, input int p);
        int dd = (d == 0) ? 65536 : d;
        int pp = (p == 0) ? 65536 : p;
        return dd * pp;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, r); chk("R1 mode", r, 0);
        rd(2'd1, r); chk("R1 count", r, 0);
        rd(2'd2, r); chk("R1 status", r, 0);
        chk("R1 outs", {evt_flag, irq, wdt_rst}, 0);

        // R2/R3 sweep of small divider and period values, single shot
        for (int d = 1; d <= 4; d++) begin
            for (int p = 1; p <= 4; p++) begin
                start(d[15:0], p[15:0], M_ON);
                wait_evt(0, 100, k);
                chk("R2 span", k, span(d, p));
                wr(2'd2, 32'h1);
                repeat (3 * d * p + 2) @(negedge clk);
                chk("R3 no refire", evt_flag, 0);
            end
        end

        // R2 zero fields mean 65536
        start(16'd0, 16'd1, M_ON);
        wait_evt(0, 70000, k);
        chk("R2 div zero", k, 65536);
        start(16'd1, 16'd0, M_ON);
        wait_evt(0, 70000, k);
        chk("R2 per zero", k, 65536);

        // R4 continuous spacing
        for (int i = 0; i < 3; i++) begin
            int d = (i == 0) ? 2 : (i == 1) ? 3 : 1;
            int p = (i == 0) ? 3 : (i == 1) ? 1 : 5;
            start(d[15:0], p[15:0], M_ON | M_CONT);
            wait_evt(0, 100, k);
            chk("R4 first", k, d * p);
            for (int j = 0; j < 2; j++) begin
                wr(2'd2, 32'h1);
                wait_evt(0, 100, k);
                chk("R4 repeat", k, d * p - 1);
            end
        end

        // R6 set wins over clear, upper status bits read zero
        start(16'd1, 16'd1, M_ON | M_CONT);
        wr(2'd2, 32'h1);
        rd(2'd2, r); chk("R6 set wins", r, 32'h1);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, r); chk("R6 cleared", r, 0);

        // R5 wrong function code and stop
        start(16'd1, 16'd2, 32'h0000_1003);
        repeat (20) @(negedge clk);
        chk("R5 fn not timer", evt_flag, 0);
        start(16'd2, 16'd4, M_ON);
        wr(2'd0, 32'h0000_0004);
        repeat (20) @(negedge clk);
        chk("R5 stopped", evt_flag, 0);

        // R7 interrupt gating
        start(16'd1, 16'd2, M_ON | M_IRQ);
        wait_evt(0, 100, k);
        chk("R7 irq on", irq, 1);
        start(16'd1, 16'd2, M_ON);
        wait_evt(0, 100, k);
        chk("R7 irq off", {evt_flag, irq}, 2'b10);

        // R10 keep-alive without watchdog: no restart, mode unchanged
        start(16'd4, 16'd4, M_ON);
        wr(2'd0, M_KICK);
        rd(2'd0, r); chk("R10 mode kept", r, M_ON);
        wait_evt(0, 100, k);
        chk("R10 no restart", k, 15);

        // R8/R9/R10 watchdog
        start(16'd4, 16'd4, M_ON | M_WDT | M_IRQ | 32'h00F0_0000);
        rd(2'd0, r); chk("R8 readback", r, 32'h0000_9004);
        wr(2'd0, M_KICK);
        rd(2'd0, r); chk("R10 kick keeps mode", r, 32'h0000_9004);
        wait_evt(1, 100, k);
        chk("R10 kick restarts", k, 16);
        rd(2'd2, r); chk("R9 status", r, 32'h2);
        chk("R9 no irq", irq, 0);
        @(negedge clk);
        chk("R9 one clock", wdt_rst, 0);
        wait_evt(1, 100, k);
        chk("R9 reload", k, 14);
        wr(2'd0, 32'h0);

        // R11 count write while running
        start(16'd2, 16'd5, M_ON);
        wr(2'd1, {16'd1, 16'd3});
        wait_evt(0, 100, k);
        chk("R11 restart", k, 3);

        // R12 rearm from parked single shot
        start(16'd2, 16'd2, M_ON);
        wait_evt(0, 100, k);
        chk("R12 first", k, 4);
        wr(2'd2, 32'h1);
        wr(2'd1, {16'd2, 16'd3});
        wait_evt(0, 100, k);
        chk("R12 rearm", k, 6);

        finish_run();
    end
endmodule